// File: doc/BRIEF.md
# Multicart Outer Bank Address Combiner

This block sits next to an inner bank controller of the common scanline-counting kind found on cartridge boards. It widens that controller's reach to a large multi-game ROM. Four outer configuration registers live in the CPU window that starts at $6000. Their bits decide, one address bit at a time, whether a bank bit comes from the inner controller or from a fixed outer offset. The result is a 12-bit PRG bank number (8 KiB units) and a 10-bit CHR bank number (1 KiB units).

A fixed-bank mode replaces the inner banking altogether. In that mode the low PRG bank bits follow CPU A13/A14, giving 16 KiB or 32 KiB pages, and the low three CHR bank bits follow PPU A12..A10. A lock bit freezes the configuration. The one exception is the CHR outer register, which is guarded by its own partial-write rule instead. The block also turns the inner controller's RAM-protect bits into read and write permissions for the work RAM at $6000-$7FFF. When the read permission is low, the host returns open bus.

The bank outputs are combinational from the stored registers and the current address. A register write therefore shows up on the outputs right after the clock edge that captures it.

Top module: `mc_outer_bank`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears all four outer registers. With inner_prg=0xFF this gives prg_bank=0x03F, and with inner_chr=0xAB it gives chr_bank=0x0AB.
- R2: A write stores cpu_wdata only when cpu_wr is high and address bits 15..13 equal 3'b011. Address bits 2..0 pick registers 0..3. Indices 4..7, and writes outside the window, change nothing.
- R3: While register 3 bit 7 is set, writes to registers 0, 1 and 3 are ignored and writes to register 2 still land.
- R4: When register 2 already holds bit 7 set, a write to it keeps the stored bits 7..4 and takes only bits 3..0 from cpu_wdata.
- R5: During a write to register 2, every bit among written bits 3..1 whose partner among the stored bits 6..4 is set is cleared (stored bit 4 clears bit 1, stored bit 5 clears bit 2, stored bit 6 clears bit 3).
- R6: The PRG inner mask is built from five terms: bits 3..0 unless register 3 bit 4 is set; bit 4 unless register 0 bit 6 is set; bit 5 unless register 1 bit 7 is set; bit 6 when register 1 bit 6 is set; bit 7 when register 1 bit 5 is set. prg_bank equals inner_prg under that mask OR-ed with the offset outside it.
- R7: The PRG outer offset places register 3 bits 3..1 at bank bits 3..1, register 0 bits 2..0 at 6..4, register 1 bit 4 at 7, register 1 bits 3..2 at 9..8, and register 0 bits 5..4 at 11..10.
- R8: In fixed-bank mode (register 3 bit 4 set), prg_bank bit 0 follows CPU A13. Bit 1 follows CPU A14 when register 1 bit 1 is set. Otherwise bit 1 comes from the offset.
- R9: In normal mode the CHR inner mask is 0xFF, or 0x7F when register 0 bit 7 is set. The CHR offset puts register 0 bits 6..4 at bank bits 9..7 and register 2 bits 3..0 at bank bits 6..3. Offset bits under the mask are dropped.
- R10: In fixed-bank mode inner_chr is ignored, and chr_bank bits 2..0 equal PPU A12..A10 (ppu_a).
- R11: wram_rd_en is high when the address is in the window and RAM-protect bit 7 or bit 5 is set.
- R12: wram_wr_en is high when the address is in the window and either (bit 7 set and bit 6 clear) or bit 5 is set.
- R13: A captured register write changes the bank outputs right after that clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_a_top | input | 3 | CPU address bits 15..13 |
| cpu_a_low | input | 3 | CPU address bits 2..0 (register index) |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| inner_prg | input | 8 | 8 KiB PRG bank number from the inner controller |
| inner_chr | input | 8 | 1 KiB CHR bank number from the inner controller |
| ppu_a | input | 3 | PPU address bits 12..10 |
| ram_prot | input | 3 | Inner RAM-protect register bits 7..5 |
| prg_bank | output | 12 | Final PRG ROM bank number |
| chr_bank | output | 10 | Final CHR ROM bank number |
| wram_rd_en | output | 1 | Work-RAM read permitted |
| wram_wr_en | output | 1 | Work-RAM write permitted |

## Verification
On every cycle the assertions check the following:
- registers are zero after reset;
- the lock freezes registers 0, 1 and 3;
- the upper nibble of register 2 is kept and its bits 3..1 are cleared under the stored mask;
- the low bank bits track the address in fixed-bank mode;
- the normal-mode CHR passthrough holds;
- write permission never exceeds read permission.

The exact bit placement of the PRG and CHR offsets, the interplay of the five PRG mask terms, window and index decoding, and the update timing of a write can only be shown by the bench's scenarios. Those scenarios drive chosen register values and compare the bank numbers against hand-computed results.

// File: rtl/mc_outer_bank.sv
module mc_outer_bank #(
  parameter logic [2:0] WINDOW_HI = 3'b011
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:13] cpu_a_top,
  input  logic [2:0]  cpu_a_low,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_wr,
  input  logic [7:0]  inner_prg,
  input  logic [7:0]  inner_chr,
  input  logic [2:0]  ppu_a,
  input  logic [7:5]  ram_prot,
  output logic [11:0] prg_bank,
  output logic [9:0]  chr_bank,
  output logic        wram_rd_en,
  output logic        wram_wr_en
);
  localparam int PW = 12;
  localparam int CW = 10;
  localparam int IW = 8;

  logic [7:0] cfg0, cfg1, cfg2, cfg3;
  logic       in_win, wr_hit, locked, fixed;
  logic [7:0] cfg2_next;

  assign in_win = (cpu_a_top == WINDOW_HI);
  assign wr_hit = cpu_wr && in_win;
  assign locked = cfg3[7];
  assign fixed  = cfg3[4];

  always_comb begin
    cfg2_next = cfg2[7] ? {cfg2[7:4], cpu_wdata[3:0]} : cpu_wdata;
    cfg2_next[3:1] = cfg2_next[3:1] & ~cfg2[6:4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg0 <= '0;
      cfg1 <= '0;
      cfg2 <= '0;
      cfg3 <= '0;
    end else if (wr_hit) begin
      case (cpu_a_low)
        3'd0: if (!locked) cfg0 <= cpu_wdata;
        3'd1: if (!locked) cfg1 <= cpu_wdata;
        3'd2: cfg2 <= cfg2_next;
        3'd3: if (!locked) cfg3 <= cpu_wdata;
        default: ;
      endcase
    end
  end

  logic [IW-1:0] prg_in_mask;
  logic [1:0]    prg_fix_mask;
  logic [PW-1:0] prg_off, prg_keep;

  assign prg_in_mask  = {cfg1[5], cfg1[6], ~cfg1[7], ~cfg0[6], {4{~fixed}}};
  assign prg_fix_mask = fixed ? {cfg1[1], 1'b1} : 2'b00;
  assign prg_off      = {cfg0[5:4], cfg1[3:2], cfg1[4], cfg0[2:0], cfg3[3:1], 1'b0};
  assign prg_keep     = {{(PW-IW){1'b0}}, prg_in_mask} | {{(PW-2){1'b0}}, prg_fix_mask};
  assign prg_bank     = {{(PW-IW){1'b0}}, inner_prg & prg_in_mask}
                      | (prg_off & ~prg_keep)
                      | {{(PW-2){1'b0}}, cpu_a_top[14:13] & prg_fix_mask};

  logic [IW-1:0] chr_in_mask;
  logic [2:0]    chr_fix_mask;
  logic [CW-1:0] chr_off, chr_keep;

  assign chr_in_mask  = fixed ? '0 : {~cfg0[7], 7'h7F};
  assign chr_fix_mask = {3{fixed}};
  assign chr_off      = {cfg0[6:4], cfg2[3:0], 3'b000};
  assign chr_keep     = {{(CW-IW){1'b0}}, chr_in_mask} | {{(CW-3){1'b0}}, chr_fix_mask};
  assign chr_bank     = {{(CW-IW){1'b0}}, inner_chr & chr_in_mask}
                      | (chr_off & ~chr_keep)
                      | {{(CW-3){1'b0}}, ppu_a & chr_fix_mask};

  assign wram_rd_en = in_win && (ram_prot[7] || ram_prot[5]);
  assign wram_wr_en = in_win && ((ram_prot[7] && !ram_prot[6]) || ram_prot[5]);
endmodule

// File: rtl/mc_outer_bank_chk.sv
module mc_outer_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:13] cpu_a_top,
  input logic [2:0]  cpu_a_low,
  input logic        cpu_wr,
  input logic [7:0]  inner_chr,
  input logic [2:0]  ppu_a,
  input logic [11:0] prg_bank,
  input logic [9:0]  chr_bank,
  input logic        wram_rd_en,
  input logic        wram_wr_en,
  input logic [7:0]  cfg0,
  input logic [7:0]  cfg1,
  input logic [7:0]  cfg2,
  input logic [7:0]  cfg3
);
  logic win_wr;
  assign win_wr = cpu_wr && (cpu_a_top == 3'b011);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg0 == 8'h00 && cfg1 == 8'h00 && cfg2 == 8'h00 && cfg3 == 8'h00));

  // R3
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && cfg3[7] && cpu_a_low != 3'd2) |=> ($stable(cfg0) && $stable(cfg1) && $stable(cfg3)));

  // R4
  nibble_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && cpu_a_low == 3'd2 && cfg2[7]) |=> (cfg2[7:4] == $past(cfg2[7:4])));

  // R5
  low_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && cpu_a_low == 3'd2) |=> ((cfg2[3:1] & $past(cfg2[6:4])) == 3'b000));

  // R8
  fixed_prg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg3[4] |-> (prg_bank[0] == cpu_a_top[13] && (!cfg1[1] || prg_bank[1] == cpu_a_top[14])));

  // R10
  fixed_chr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg3[4] |-> (chr_bank[2:0] == ppu_a));

  // R9
  chr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg3[4] && !cfg0[7]) |-> (chr_bank[7:0] == inner_chr && chr_bank[9:8] == cfg0[6:5]));

  // R12
  wr_within_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wram_wr_en |-> wram_rd_en);
endmodule

bind mc_outer_bank mc_outer_bank_chk chk (
  .clk(clk), .rst_n(rst_n), .cpu_a_top(cpu_a_top), .cpu_a_low(cpu_a_low),
  .cpu_wr(cpu_wr), .inner_chr(inner_chr), .ppu_a(ppu_a),
  .prg_bank(prg_bank), .chr_bank(chr_bank),
  .wram_rd_en(wram_rd_en), .wram_wr_en(wram_wr_en),
  .cfg0(cfg0), .cfg1(cfg1), .cfg2(cfg2), .cfg3(cfg3)
);

// File: tb/mc_outer_bank_test.sv
module mc_outer_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:13] cpu_a_top = 3'b100;
  logic [2:0]  cpu_a_low = 3'd0;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        cpu_wr = 1'b0;
  logic [7:0]  inner_prg = 8'hFF;
  logic [7:0]  inner_chr = 8'hAB;
  logic [2:0]  ppu_a = 3'd0;
  logic [7:5]  ram_prot = 3'b000;
  logic [11:0] prg_bank;
  logic [9:0]  chr_bank;
  logic        wram_rd_en, wram_wr_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mc_outer_bank uut (
    .clk(clk), .rst_n(rst_n), .cpu_a_top(cpu_a_top), .cpu_a_low(cpu_a_low),
    .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr), .inner_prg(inner_prg),
    .inner_chr(inner_chr), .ppu_a(ppu_a), .ram_prot(ram_prot),
    .prg_bank(prg_bank), .chr_bank(chr_bank),
    .wram_rd_en(wram_rd_en), .wram_wr_en(wram_wr_en)
  );

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] addr, logic [7:0] data);
    @(negedge clk);
    cpu_a_top = addr[15:13];
    cpu_a_low = addr[2:0];
    cpu_wdata = data;
    cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    cpu_a_top = 3'b100;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cpu_wr = 1'b0;
    cpu_a_top = 3'b100;
    inner_prg = 8'hFF;
    inner_chr = 8'hAB;
    ppu_a = 3'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 prg", prg_bank, 12'h03F);
    check("R1 chr", {2'b00, chr_bank}, 12'h0AB);
  endtask

  task automatic t_window();
    do_reset();
    wr(16'h5000, 8'h07);
    check("R2 below window", prg_bank, 12'h03F);
    wr(16'h8000, 8'h07);
    check("R2 above window", prg_bank, 12'h03F);
    wr(16'h7FF8, 8'h07);
    check("R2 index 0 alias", prg_bank, 12'h07F);
    wr(16'h6004, 8'h40);
    check("R2 index 4 ignored", prg_bank, 12'h07F);
  endtask

  task automatic t_prg_normal();
    do_reset();
    wr(16'h6000, 8'h35);
    check("R7 reg0 offset", prg_bank, 12'hC7F);
    check("R9 chr offset", {2'b00, chr_bank}, 12'h1AB);
    wr(16'h6000, 8'h40);
    check("R6 reg0 bit6", prg_bank, 12'h02F);
    wr(16'h6000, 8'h00);
    wr(16'h6001, 8'hE0);
    check("R6 reg1 bits7..5", prg_bank, 12'h0DF);
    wr(16'h6001, 8'h1C);
    check("R7 reg1 offset", prg_bank, 12'h3BF);
    inner_prg = 8'h00;
    #1;
    check("R7 reg1 offset inner zero", prg_bank, 12'h380);
  endtask

  task automatic t_chr_normal();
    do_reset();
    wr(16'h6000, 8'hF0);
    inner_chr = 8'hFF;
    #1;
    check("R9 mask 7F", {2'b00, chr_bank}, 12'h3FF);
    inner_chr = 8'h00;
    #1;
    check("R9 mask 7F inner zero", {2'b00, chr_bank}, 12'h380);
  endtask

  task automatic t_fixed();
    do_reset();
    inner_prg = 8'h00;
    inner_chr = 8'hFF;
    wr(16'h6002, 8'h05);
    wr(16'h6003, 8'h1A);
    cpu_a_top = 3'b111;
    #1;
    check("R8 16K A13=1", prg_bank, 12'h00B);
    cpu_a_top = 3'b110;
    #1;
    check("R8 16K A13=0", prg_bank, 12'h00A);
    wr(16'h6001, 8'h02);
    cpu_a_top = 3'b110;
    #1;
    check("R8 32K A14=1 A13=0", prg_bank, 12'h00A);
    cpu_a_top = 3'b101;
    #1;
    check("R8 32K A14=0 A13=1", prg_bank, 12'h009);
    ppu_a = 3'd6;
    #1;
    check("R10 chr fixed", {2'b00, chr_bank}, 12'h02E);
    ppu_a = 3'd1;
    #1;
    check("R10 chr fixed a", {2'b00, chr_bank}, 12'h029);
  endtask

  task automatic t_reg2();
    do_reset();
    wr(16'h6003, 8'h10);
    wr(16'h6002, 8'h30);
    wr(16'h6002, 8'h0F);
    check("R5 bits 2,1 cleared", {2'b00, chr_bank}, 12'h048);
    wr(16'h6002, 8'hF0);
    wr(16'h6002, 8'h0F);
    check("R4 R5 merge and mask", {2'b00, chr_bank}, 12'h008);
    wr(16'h6002, 8'h0E);
    check("R4 upper kept", {2'b00, chr_bank}, 12'h000);
  endtask

  task automatic t_lock();
    do_reset();
    inner_prg = 8'h00;
    wr(16'h6003, 8'h90);
    wr(16'h6000, 8'h70);
    check("R3 reg0 locked", {2'b00, chr_bank}, 12'h000);
    wr(16'h6002, 8'h03);
    check("R3 reg2 open", {2'b00, chr_bank}, 12'h018);
    wr(16'h6003, 8'h00);
    ppu_a = 3'd5;
    #1;
    check("R3 reg3 locked", {2'b00, chr_bank}, 12'h01D);
    cpu_a_top = 3'b101;
    #1;
    check("R3 prg still fixed", prg_bank, 12'h001);
  endtask

  task automatic t_wram();
    cpu_a_top = 3'b011;
    ram_prot = 3'b100; #1;
    check("R11 rd p7", {11'd0, wram_rd_en}, 12'd1);
    check("R12 wr p7", {11'd0, wram_wr_en}, 12'd1);
    ram_prot = 3'b110; #1;
    check("R11 rd p7p6", {11'd0, wram_rd_en}, 12'd1);
    check("R12 wr p7p6", {11'd0, wram_wr_en}, 12'd0);
    ram_prot = 3'b011; #1;
    check("R11 rd p6p5", {11'd0, wram_rd_en}, 12'd1);
    check("R12 wr p6p5", {11'd0, wram_wr_en}, 12'd1);
    ram_prot = 3'b010; #1;
    check("R11 rd p6", {11'd0, wram_rd_en}, 12'd0);
    check("R12 wr p6", {11'd0, wram_wr_en}, 12'd0);
    cpu_a_top = 3'b100;
    ram_prot = 3'b101; #1;
    check("R11 rd outside", {11'd0, wram_rd_en}, 12'd0);
    check("R12 wr outside", {11'd0, wram_wr_en}, 12'd0);
    ram_prot = 3'b000;
  endtask

  task automatic t_timing();
    do_reset();
    @(negedge clk);
    cpu_a_top = 3'b011;
    cpu_a_low = 3'd0;
    cpu_wdata = 8'h07;
    cpu_wr = 1'b1;
    #1;
    check("R13 before edge", prg_bank, 12'h03F);
    @(posedge clk);
    #1;
    check("R13 after edge", prg_bank, 12'h07F);
    @(negedge clk);
    cpu_wr = 1'b0;
    cpu_a_top = 3'b100;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_window();
    t_prg_normal();
    t_chr_normal();
    t_fixed();
    t_reg2();
    t_lock();
    t_wram();
    t_timing();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule